// File: doc/BRIEF.md
# MDIO Management Frame Master

This block drives a two-wire management bus (MDC clock, bidirectional MDIO data) toward one or more Ethernet PHYs. Software controls it through a single 32-bit command word. The word holds the raw start code, the operation code, a port address, a register or device address and a 16-bit data field. When software writes the word with its top bit set, the block sends exactly one management frame. The frame is built from those fields, preceded by a preamble of ones and carrying a two-bit turnaround.

The block does not interpret the start code or the operation code. It sends them as given, so the same engine produces Clause 22 reads and writes and each of the Clause 45 frame kinds: address, write, read and post-read-increment. A Clause 45 register access is two commands issued one after the other by software, an address frame first and then a data frame. The top bit stays set while the frame is in flight, and software polls it. When a read finishes, the returned 16 bits are placed in the low half of the command word.

MDC comes from the system clock through a divider. Its half period is set by a parameter. MDIO changes only on falling MDC edges, and read data is captured on rising edges.

Top module: `mdio_cmd_master`

## Requirements
- R1: After reset the command word reads zero, MDC is low and MDIO is released (`mdio_oe` low).
- R2: A write with bit 31 set, while bit 31 reads zero, starts one frame. Bit 31 then reads one until the frame ends and reads zero afterwards.
- R3: A frame is 64 bit times, sent MSB first: 32 ones, then the start code from bits 17:16, the operation code from bits 19:18, the port address from bits 24:20 and the register/device address from bits 29:25.
- R4: When bit 19 is zero (write or address frames), the master drives all 64 bits. Turnaround is sent as 1 then 0, followed by bits 15:0. The low half of the word is unchanged after the frame.
- R5: When bit 19 is one (read and post-read-increment frames), `mdio_oe` is low for the last 18 bit times. The 16 bits sampled on the rising MDC edges of the last 16 bit times appear in bits 15:0 when bit 31 clears, first bit received in bit 15.
- R6: MDIO output only changes while MDC is low. It is stable across every rising MDC edge.
- R7: A write to the command word while bit 31 reads one is ignored. The frame in flight and the fields read back are unaffected, and no extra frame follows.
- R8: Bit 30 always reads zero, whatever was written.
- R9: MDC high and low phases each last HALF_DIV system clock cycles, so one bit time is 2*HALF_DIV cycles.
- R10: Once a frame ends, MDC rests low, MDIO is released, and bits 29:16 still hold the values written.
- R11: A write with bit 31 clear stores the fields, which then read back, but starts no frame. MDC stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_wr | input | 1 | Write strobe for the command word |
| cmd_wdata | input | 32 | Value written to the command word |
| cmd_rdata | output | 32 | Current command word with status and read data |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable, low when released |
| mdio_i | input | 1 | MDIO input value from the pad |

## Verification
The bench records MDIO and its enable on every rising MDC edge and compares the 64 recorded bits with a frame that a bench function builds from the command word. It checks read frames bit by bit for the 18-bit release window. If the design released MDIO too early or too late, it would fight the PHY or lose the turnaround. If it misordered the read bits, bits 15:0 would come back reversed or shifted. The bench also issues a second start while a frame is still running. A design that did not guard against this would corrupt the fields or send a second frame, which shows up as extra MDC edges. Random commands cover both start codes and all four operation codes, with bit 30 set at random to catch a leaking reserved bit.

// File: rtl/mdio_cmd_pkg.sv
// Shared field positions of the command word and frame geometry.
package mdio_cmd_pkg;
    localparam int CMD_W       = 32;
    localparam int DATA_W      = 16;
    localparam int PRE_LEN     = 32;
    localparam int FRAME_LEN   = 64;
    localparam int IDX_W       = $clog2(FRAME_LEN);
    localparam int GO_BIT      = 31;
    localparam int RSVD_BIT    = 30;
    localparam int RD_OP_BIT   = 19;
    // bit time from which a read frame releases MDIO (turnaround start)
    localparam int TA_IDX      = FRAME_LEN - DATA_W - 2;
    // bit time of the first returned data bit
    localparam int RX_IDX      = FRAME_LEN - DATA_W;
endpackage

// File: rtl/mdio_tick_gen.sv
// Half-period strobe generator for MDC.
// Assumes HALF_DIV >= 2; the count restarts whenever en is low.
module mdio_tick_gen #(
    parameter int HALF_DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic tick
);
    localparam int CNT_W = (HALF_DIV > 2) ? $clog2(HALF_DIV) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(HALF_DIV - 1);

    logic [CNT_W-1:0] cnt;

    // count system clocks within one MDC half period
    always_ff @(posedge clk) begin
        if (!rst_n || !en)
            cnt <= '0;
        else if (cnt == LAST)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end

    assign tick = en && (cnt == LAST);
endmodule

// File: rtl/mdio_frame_engine.sv
// Serialises one 64-bit management frame from the command word.
// Assumes cmd stays stable from start until done. MDC idles low, MDIO
// changes on the falling edge and read data is taken on the rising edge.
module mdio_frame_engine
    import mdio_cmd_pkg::*;
#(
    parameter int HALF_DIV = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [CMD_W-1:0]  cmd,
    input  logic              mdio_i,
    output logic              mdc,
    output logic              mdio_o,
    output logic              mdio_oe,
    output logic              done,
    output logic [DATA_W-1:0] rx_data
);
    logic             running;
    logic             mdc_q;
    logic [IDX_W-1:0] bit_idx;
    logic             tick;
    logic             is_read;
    logic [FRAME_LEN-1:0] frame;

    mdio_tick_gen #(.HALF_DIV(HALF_DIV)) u_tick (
        .clk  (clk),
        .rst_n(rst_n),
        .en   (running),
        .tick (tick)
    );

    assign is_read = cmd[RD_OP_BIT];
    assign frame   = {{PRE_LEN{1'b1}}, cmd[17:16], cmd[19:18],
                      cmd[24:20], cmd[29:25], 2'b10, cmd[15:0]};

    // advance MDC phase, bit index and receive shifter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            running <= 1'b0;
            mdc_q   <= 1'b0;
            bit_idx <= '0;
            rx_data <= '0;
        end else if (start) begin
            running <= 1'b1;
            mdc_q   <= 1'b0;
            bit_idx <= '0;
        end else if (running && tick) begin
            if (!mdc_q) begin
                mdc_q <= 1'b1;
                if (is_read && (bit_idx >= IDX_W'(RX_IDX)))
                    rx_data <= {rx_data[DATA_W-2:0], mdio_i};
            end else begin
                mdc_q <= 1'b0;
                if (bit_idx == IDX_W'(FRAME_LEN - 1))
                    running <= 1'b0;
                else
                    bit_idx <= bit_idx + 1'b1;
            end
        end
    end

    assign mdc     = mdc_q;
    assign mdio_o  = running ? frame[~bit_idx] : 1'b0;
    assign mdio_oe = running && !(is_read && (bit_idx >= IDX_W'(TA_IDX)));
    assign done    = running && tick && mdc_q && (bit_idx == IDX_W'(FRAME_LEN - 1));

    AST_MDIO_STABLE_AT_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mdc_q) |-> $stable(mdio_o));                       // R6
    AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        $past(done) |-> (!mdio_oe && !mdc_q));                    // R10
endmodule

// File: rtl/mdio_cmd_master.sv
// MDIO master controlled by one self-clearing 32-bit command word.
// Assumes software polls bit 31 before issuing the next command;
// writes while busy are dropped.
module mdio_cmd_master
    import mdio_cmd_pkg::*;
#(
    parameter int HALF_DIV = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cmd_wr,
    input  logic [31:0] cmd_wdata,
    output logic [31:0] cmd_rdata,
    output logic        mdc,
    output logic        mdio_o,
    output logic        mdio_oe,
    input  logic        mdio_i
);
    logic [CMD_W-1:0]  cmd_q;
    logic              busy;
    logic              go;
    logic              eng_done;
    logic [DATA_W-1:0] eng_rx;

    assign busy = cmd_q[GO_BIT];
    assign go   = cmd_wr && !busy && cmd_wdata[GO_BIT];

    // hold the command word, clear go and store read data at frame end
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q <= '0;
        end else if (cmd_wr && !busy) begin
            cmd_q           <= cmd_wdata;
            cmd_q[RSVD_BIT] <= 1'b0;
        end else if (eng_done) begin
            cmd_q[GO_BIT] <= 1'b0;
            if (cmd_q[RD_OP_BIT])
                cmd_q[DATA_W-1:0] <= eng_rx;
        end
    end

    mdio_frame_engine #(.HALF_DIV(HALF_DIV)) u_engine (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (go),
        .cmd    (cmd_q),
        .mdio_i (mdio_i),
        .mdc    (mdc),
        .mdio_o (mdio_o),
        .mdio_oe(mdio_oe),
        .done   (eng_done),
        .rx_data(eng_rx)
    );

    assign cmd_rdata = cmd_q;

    AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !eng_done) |=> busy);                            // R2
    AST_BUSY_WRITE_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cmd_wr) |=> $stable(cmd_q[29:16]));              // R7
    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_rdata[RSVD_BIT] == 1'b0);                             // R8
    AST_MDC_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !$past(go)) |-> !mdc);                          // R11
endmodule

// File: tb/mdio_cmd_master_test.sv
module mdio_cmd_master_test;
    localparam int HALF = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_wr = 1'b0;
    logic [31:0] cmd_wdata = '0;
    logic [31:0] cmd_rdata;
    logic        mdc, mdio_o, mdio_oe;
    logic        mdio_i = 1'b1;

    int errors = 0;
    int checks = 0;
    int cyc = 0;
    int rc = 0;
    int rise_t [2];
    logic cap_o [64];
    logic cap_oe [64];
    logic mdc_prev = 1'b0;
    logic [15:0] phy_val = '0;
    int seed_dummy;

    mdio_cmd_master #(.HALF_DIV(HALF)) uut (
        .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_wdata(cmd_wdata),
        .cmd_rdata(cmd_rdata), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
        .mdio_i(mdio_i)
    );

    always #5 clk = ~clk;

    // bus monitor and PHY model: record on rising MDC, present read data while MDC low
    always @(negedge clk) begin
        cyc = cyc + 1;
        if (mdc && !mdc_prev) begin
            if (rc < 64) begin
                cap_o[rc]  = mdio_o;
                cap_oe[rc] = mdio_oe;
            end
            if (rc < 2) rise_t[rc] = cyc;
            rc = rc + 1;
        end
        mdc_prev = mdc;
        if (!mdc) mdio_i = (rc >= 48 && rc < 64) ? phy_val[63-rc] : 1'b1;
    end

    always @(negedge clk) begin
        if (cyc == 150000) begin
            errors = errors + 1;
            checks = checks + 1;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [63:0] exp_frame(input logic [31:0] c);
        return {32'hFFFF_FFFF, c[17:16], c[19:18], c[24:20], c[29:25], 2'b10, c[15:0]};
    endfunction

    function automatic logic [63:0] exp_enable(input logic [31:0] c);
        return c[19] ? {46'h3FFF_FFFF_FFFF, 18'h0} : 64'hFFFF_FFFF_FFFF_FFFF;
    endfunction

    function automatic logic [31:0] exp_readback(input logic [31:0] c, input logic [15:0] pv);
        return {2'b00, c[29:16], c[19] ? pv : c[15:0]};
    endfunction

    task automatic write_cmd(input logic [31:0] v);
        @(negedge clk);
        cmd_wr = 1'b1;
        cmd_wdata = v;
        @(negedge clk);
        cmd_wr = 1'b0;
    endtask

    task automatic wait_idle(output bit ok);
        ok = 1'b0;
        for (int i = 0; i < 4000; i++) begin
            @(negedge clk);
            if (!cmd_rdata[31]) begin ok = 1'b1; break; end
        end
    endtask

    task automatic run_frame(input logic [31:0] c, input logic [15:0] pv);
        logic [63:0] got_o, got_oe, ef, ee;
        bit ok;
        rc = 0;
        phy_val = pv;
        write_cmd(c);
        check(cmd_rdata[31] == 1'b1, "R2 busy set after start", {63'd0, cmd_rdata[31]}, 64'd1);
        wait_idle(ok);
        check(ok, "R2 busy clears", {63'd0, cmd_rdata[31]}, 64'd0);
        for (int j = 0; j < 64; j++) begin
            got_o[63-j]  = cap_o[j];
            got_oe[63-j] = cap_oe[j];
        end
        ef = exp_frame(c);
        ee = exp_enable(c);
        check(rc == 64, "R3 bit times per frame", 64'(rc), 64'd64);
        check((got_o[63:18] == ef[63:18]) && (got_oe[63:18] == ee[63:18]),
              "R3 preamble/st/op/addr", got_o, ef);
        if (c[19])
            check(got_oe == ee, "R5 release window", got_oe, ee);
        else
            check((got_oe == ee) && (got_o[17:0] == ef[17:0]),
                  "R4 turnaround and data driven", got_o, ef);
        check(cmd_rdata == exp_readback(c, pv), c[19] ? "R5 read data" : "R4 data kept",
              {32'd0, cmd_rdata}, {32'd0, exp_readback(c, pv)});
        check(cmd_rdata[30] == 1'b0, "R8 reserved bit", {63'd0, cmd_rdata[30]}, 64'd0);
        check(!mdc && !mdio_oe && cmd_rdata[29:16] == c[29:16], "R10 idle after frame",
              {62'd0, mdc, mdio_oe}, 64'd0);
    endtask

    initial begin
        logic [31:0] c;
        bit ok;
        seed_dummy = $urandom(32'h5EED_1234);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(cmd_rdata == 32'd0, "R1 word after reset", {32'd0, cmd_rdata}, 64'd0);
        check(!mdc, "R1 mdc low", {63'd0, mdc}, 64'd0);
        check(!mdio_oe, "R1 mdio released", {63'd0, mdio_oe}, 64'd0);

        // R11: store without go
        rc = 0;
        write_cmd(32'h4ABC_1234);
        repeat (100) @(negedge clk);
        check(cmd_rdata == 32'h0ABC_1234, "R11 fields stored, R8 bit30", {32'd0, cmd_rdata}, 64'h0ABC_1234);
        check(rc == 0 && !mdc, "R11 no frame", 64'(rc), 64'd0);

        // directed: clause 22 write, clause 22 read, clause 45 address and read
        run_frame(32'h8000_0000 | (32'd3 << 25) | (32'd1 << 20) | (32'd1 << 18) | (32'd1 << 16) | 32'hA5A5, 16'h0);
        run_frame(32'h8000_0000 | (32'd31 << 25) | (32'd31 << 20) | (32'd2 << 18) | (32'd1 << 16), 16'hC3E1);
        run_frame(32'h8000_0000 | (32'd7 << 25) | (32'd2 << 20) | 32'h8001, 16'h0);
        run_frame(32'h8000_0000 | (32'd7 << 25) | (32'd2 << 20) | (32'd3 << 18), 16'h8001);

        // R9: one bit time is 2*HALF cycles
        check(rise_t[1] - rise_t[0] == 2 * HALF, "R9 mdc period",
              64'(rise_t[1] - rise_t[0]), 64'(2 * HALF));

        // R7: write while busy ignored
        rc = 0;
        phy_val = 16'h0;
        c = 32'h8000_0000 | (32'd9 << 25) | (32'd4 << 20) | (32'd1 << 18) | (32'd1 << 16) | 32'h1357;
        write_cmd(c);
        repeat (120) @(negedge clk);
        write_cmd(32'hFFFF_FFFF);
        wait_idle(ok);
        check(ok && cmd_rdata == exp_readback(c, 16'h0), "R7 fields unchanged",
              {32'd0, cmd_rdata}, {32'd0, exp_readback(c, 16'h0)});
        repeat (200) @(negedge clk);
        check(rc == 64 && !mdc, "R7 no extra frame", 64'(rc), 64'd64);

        // random commands
        for (int k = 0; k < 10; k++) begin
            c = $urandom;
            c[31] = 1'b1;
            c[17] = 1'b0;
            run_frame(c, 16'($urandom));
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule